// File: doc/BRIEF.md
# Two-Phase Operand and Result Routing Datapath

This block is the register-and-multiplexer network that sits around the ALU of a 32-bit execution unit. It picks the left and right ALU operands and a store-data value. The sources are the two RAM read ports, a constant register loaded from the instruction unit, a field register, a shared common result bus, and the stage-2 result, which is forwarded back into the operand and store-data muxes. Results and store data then move through stage-2 and stage-3 registers toward a memory-bus driver register. The stage-3 result returns to the common bus, which it shares with incoming memory data.

The block runs on one clock and takes two phase enables, A and B, that are never high in the same cycle. Every register loads only in its own phase. Each register has a one-hot select vector with one bit per source, and an all-zero select holds the register's value. The common bus has two drivers, both gated by phase B. When neither driver is enabled, the bus keeps the last value driven onto it.

Top module: `opnd_route_dp`

## Requirements
- R1: While reset is high, every register and the common-bus keeper are cleared to zero at each clock edge.
- R2: The left operand loads only on phase A, from select bit 0 = RAM port A, bit 1 = stage-2 result, bit 2 = common bus.
- R3: The right operand loads only on phase A, from select bit 0 = RAM port B, bit 1 = stage-2 result, bit 2 = common bus, bit 3 = instruction-unit input, bit 4 = field register.
- R4: The store-data path works in three steps. Stage-2A loads on phase A from bit 0 = RAM port B, bit 1 = stage-2 result, bit 2 = common bus. Stage-2B loads on phase B from stage-2A. Stage-3A loads on phase A from bit 0 = stage-2B, bit 1 = common bus.
- R5: The stage-2 result loads on phase B from bit 0 = ALU output, bit 1 = field-unit output, bit 2 = left operand.
- R6: The stage-3 result loads on phase A from the stage-2 result. It drives the common bus when its driver enable and phase B are both high.
- R7: Memory input data drives the common bus when its driver enable and phase B are both high. With no driver active, the bus shows the value held by the keeper, which is updated at each edge where a driver is active.
- R8: The constant register loads on phase B from the instruction-unit input. The field register loads on phase A from the common bus.
- R9: The memory-bus driver register loads on phase B from bit 0 = stage-3 store data, bit 1 = stage-2 result.
- R10: A register whose select is all zero, or whose phase enable is low, keeps its value.
- R11: At most one select bit per register, at most one common-bus driver, and at most one phase enable are high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ph_a | input | 1 | Phase A enable |
| ph_b | input | 1 | Phase B enable |
| ram_a_rd | input | 32 | RAM read port A |
| ram_b_rd | input | 32 | RAM read port B |
| ifu_in | input | 32 | Instruction-unit input |
| alu_res | input | 32 | ALU output |
| fu_res | input | 32 | Field-unit output |
| mem_in | input | 32 | Incoming memory-bus data |
| sel_const | input | 1 | Constant register select |
| sel_right | input | 5 | Right operand select |
| sel_field | input | 1 | Field register select |
| sel_left | input | 3 | Left operand select |
| sel_st2a | input | 3 | Stage-2A store-data select |
| sel_st2b | input | 1 | Stage-2B store-data select |
| sel_st3a | input | 2 | Stage-3A store-data select |
| sel_res2 | input | 3 | Stage-2 result select |
| sel_res3 | input | 1 | Stage-3 result select |
| sel_mdrv | input | 2 | Memory driver register select |
| drv_res3 | input | 1 | Stage-3 result common-bus driver enable |
| drv_mem | input | 1 | Memory input common-bus driver enable |
| left_opnd | output | 32 | Left operand register |
| right_opnd | output | 32 | Right operand register |
| const_q | output | 32 | Constant register |
| field_q | output | 32 | Field register |
| res2_q | output | 32 | Stage-2 result register |
| mdrv_q | output | 32 | Memory-bus driver register |
| cbus | output | 32 | Common result bus value |

## Verification
The hardest values to reach are the ones that cross both phases several times before they reach a port. One example is an ALU result that goes to stage 2, then stage 3, then onto the common bus, then into the field register, and finally into the right operand. Another is store data that moves from RAM through stage-2A, stage-2B and stage-3A into the memory driver. The stimulus table walks these chains one phase per row, with distinct data on every input, so that each observed value identifies the path it took. Directed steps then cover wrong-phase loads, all-zero selects and the bus keeper when no driver is active.

// File: rtl/opnd_route_pkg.sv
package opnd_route_pkg;
  localparam int unsigned DW = 32;
  typedef logic [DW-1:0] word_t;
endpackage

// File: rtl/dp_route_reg.sv
module dp_route_reg #(
  parameter int unsigned W = 32,
  parameter int unsigned N = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ph_en,
  input  logic [N-1:0]        sel,
  input  logic [N-1:0][W-1:0] din,
  output logic [W-1:0]        q
);
  logic [W-1:0] mux_val;
  logic         load;

  always_comb begin
    mux_val = '0;
    for (int i = 0; i < N; i++) begin
      if (sel[i]) mux_val = mux_val | din[i];
    end
  end

  assign load = ph_en && (|sel);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (load) q <= mux_val;
  end

  // R11
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(sel));

  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!ph_en || sel == '0) |=> q == $past(q));
endmodule

// File: rtl/dp_cbus.sv
module dp_cbus #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ph_b,
  input  logic         drv_res3,
  input  logic         drv_mem,
  input  logic [W-1:0] res3,
  input  logic [W-1:0] mem_in,
  output logic [W-1:0] bus
);
  logic         en_r, en_m;
  logic [W-1:0] keep;

  assign en_r = ph_b && drv_res3;
  assign en_m = ph_b && drv_mem;

  always_comb begin
    if (en_r)      bus = res3;
    else if (en_m) bus = mem_in;
    else           bus = keep;
  end

  always_ff @(posedge clk) begin
    if (rst) keep <= '0;
    else if (en_r || en_m) keep <= bus;
  end

  // R11
  bus_one_drv_chk: assert property (@(posedge clk) disable iff (rst) !(drv_res3 && drv_mem));

  // R7
  keeper_track_chk: assert property (@(posedge clk) disable iff (rst)
    (en_r || en_m) |=> keep == $past(bus));
endmodule

// File: rtl/opnd_route_dp.sv
module opnd_route_dp
  import opnd_route_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ph_a,
  input  logic         ph_b,
  input  logic [W-1:0] ram_a_rd,
  input  logic [W-1:0] ram_b_rd,
  input  logic [W-1:0] ifu_in,
  input  logic [W-1:0] alu_res,
  input  logic [W-1:0] fu_res,
  input  logic [W-1:0] mem_in,
  input  logic         sel_const,
  input  logic [4:0]   sel_right,
  input  logic         sel_field,
  input  logic [2:0]   sel_left,
  input  logic [2:0]   sel_st2a,
  input  logic         sel_st2b,
  input  logic [1:0]   sel_st3a,
  input  logic [2:0]   sel_res2,
  input  logic         sel_res3,
  input  logic [1:0]   sel_mdrv,
  input  logic         drv_res3,
  input  logic         drv_mem,
  output logic [W-1:0] left_opnd,
  output logic [W-1:0] right_opnd,
  output logic [W-1:0] const_q,
  output logic [W-1:0] field_q,
  output logic [W-1:0] res2_q,
  output logic [W-1:0] mdrv_q,
  output logic [W-1:0] cbus
);
  logic [W-1:0] st2a_q, st2b_q, st3a_q, res3_q;

  // R8 constant register, phase B
  dp_route_reg #(.W(W), .N(1)) u_const (
    .clk(clk), .rst(rst), .ph_en(ph_b), .sel(sel_const),
    .din('{ifu_in}), .q(const_q));

  // R3 right operand, phase A
  dp_route_reg #(.W(W), .N(5)) u_right (
    .clk(clk), .rst(rst), .ph_en(ph_a), .sel(sel_right),
    .din('{field_q, ifu_in, cbus, res2_q, ram_b_rd}), .q(right_opnd));

  // R8 field register, phase A
  dp_route_reg #(.W(W), .N(1)) u_field (
    .clk(clk), .rst(rst), .ph_en(ph_a), .sel(sel_field),
    .din('{cbus}), .q(field_q));

  // R2 left operand, phase A
  dp_route_reg #(.W(W), .N(3)) u_left (
    .clk(clk), .rst(rst), .ph_en(ph_a), .sel(sel_left),
    .din('{cbus, res2_q, ram_a_rd}), .q(left_opnd));

  // R4 store-data stage 2A, phase A
  dp_route_reg #(.W(W), .N(3)) u_st2a (
    .clk(clk), .rst(rst), .ph_en(ph_a), .sel(sel_st2a),
    .din('{cbus, res2_q, ram_b_rd}), .q(st2a_q));

  // R5 stage-2 result, phase B
  dp_route_reg #(.W(W), .N(3)) u_res2 (
    .clk(clk), .rst(rst), .ph_en(ph_b), .sel(sel_res2),
    .din('{left_opnd, fu_res, alu_res}), .q(res2_q));

  // R4 store-data stage 2B, phase B
  dp_route_reg #(.W(W), .N(1)) u_st2b (
    .clk(clk), .rst(rst), .ph_en(ph_b), .sel(sel_st2b),
    .din('{st2a_q}), .q(st2b_q));

  // R4 store-data stage 3A, phase A
  dp_route_reg #(.W(W), .N(2)) u_st3a (
    .clk(clk), .rst(rst), .ph_en(ph_a), .sel(sel_st3a),
    .din('{cbus, st2b_q}), .q(st3a_q));

  // R9 memory-bus driver register, phase B
  dp_route_reg #(.W(W), .N(2)) u_mdrv (
    .clk(clk), .rst(rst), .ph_en(ph_b), .sel(sel_mdrv),
    .din('{res2_q, st3a_q}), .q(mdrv_q));

  // R6 stage-3 result, phase A
  dp_route_reg #(.W(W), .N(1)) u_res3 (
    .clk(clk), .rst(rst), .ph_en(ph_a), .sel(sel_res3),
    .din('{res2_q}), .q(res3_q));

  // R6, R7 common result bus with two phase-B drivers
  dp_cbus #(.W(W)) u_cbus (
    .clk(clk), .rst(rst), .ph_b(ph_b), .drv_res3(drv_res3), .drv_mem(drv_mem),
    .res3(res3_q), .mem_in(mem_in), .bus(cbus));

  // R11
  phase_excl_chk: assert property (@(posedge clk) disable iff (rst) !(ph_a && ph_b));

  // R6
  res3_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_b && drv_res3) |-> cbus == res3_q);
endmodule

// File: tb/opnd_route_dp_bench.sv
module opnd_route_dp_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RA = 32'hA000_0001, RB = 32'hB000_0002, IFV = 32'hC000_0003;
  localparam logic [31:0] AL = 32'hD000_0004, FU = 32'hE000_0005, MI = 32'hF000_0006;

  typedef struct packed {
    logic pa, pb, sk;
    logic [4:0] sr;
    logic sf;
    logic [2:0] sl, s2a;
    logic s2b;
    logic [1:0] s3a;
    logic [2:0] sr2;
    logic sr3;
    logic [1:0] sp;
    logic d3, dm;
    logic [2:0] obs;
    logic [31:0] exp;
  } vec_t;

  // obs: 0 left, 1 right, 2 const, 3 field, 4 res2, 5 mdrv, 6 cbus
  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b1,5'd0, 1'b0,3'd0,3'd0,1'b0,2'd0,3'd0,1'b0,2'd0,1'b0,1'b0,3'd2,IFV}, // R8 const
    '{1'b1,1'b0,1'b0,5'd0, 1'b0,3'd1,3'd0,1'b0,2'd0,3'd0,1'b0,2'd0,1'b0,1'b0,3'd0,RA},  // R2 ram A
    '{1'b1,1'b0,1'b0,5'd8, 1'b0,3'd0,3'd0,1'b0,2'd0,3'd0,1'b0,2'd0,1'b0,1'b0,3'd1,IFV}, // R3 ifu
    '{1'b0,1'b1,1'b0,5'd0, 1'b0,3'd0,3'd0,1'b0,2'd0,3'd1,1'b0,2'd0,1'b0,1'b0,3'd4,AL},  // R5 alu
    '{1'b1,1'b0,1'b0,5'd0, 1'b0,3'd2,3'd0,1'b0,2'd0,3'd0,1'b1,2'd0,1'b0,1'b0,3'd0,AL},  // R2 fwd res2
    '{1'b0,1'b1,1'b0,5'd0, 1'b0,3'd0,3'd0,1'b0,2'd0,3'd0,1'b0,2'd0,1'b1,1'b0,3'd6,AL},  // R6 res3 on bus
    '{1'b1,1'b0,1'b0,5'd0, 1'b1,3'd0,3'd0,1'b0,2'd0,3'd0,1'b0,2'd0,1'b0,1'b0,3'd3,AL},  // R8 field
    '{1'b1,1'b0,1'b0,5'd16,1'b0,3'd0,3'd0,1'b0,2'd0,3'd0,1'b0,2'd0,1'b0,1'b0,3'd1,AL},  // R3 field
    '{1'b0,1'b1,1'b0,5'd0, 1'b0,3'd0,3'd0,1'b0,2'd0,3'd0,1'b0,2'd0,1'b0,1'b1,3'd6,MI},  // R7 mem on bus
    '{1'b1,1'b0,1'b0,5'd4, 1'b0,3'd0,3'd0,1'b0,2'd0,3'd0,1'b0,2'd0,1'b0,1'b0,3'd1,MI},  // R3 cbus
    '{1'b1,1'b0,1'b0,5'd0, 1'b0,3'd0,3'd1,1'b0,2'd0,3'd0,1'b0,2'd0,1'b0,1'b0,3'd0,AL},  // R4 st2a
    '{1'b0,1'b1,1'b0,5'd0, 1'b0,3'd0,3'd0,1'b1,2'd0,3'd2,1'b0,2'd0,1'b0,1'b0,3'd4,FU},  // R4 st2b, R5 fu
    '{1'b1,1'b0,1'b0,5'd0, 1'b0,3'd0,3'd0,1'b0,2'd1,3'd0,1'b0,2'd0,1'b0,1'b0,3'd1,MI},  // R4 st3a
    '{1'b0,1'b1,1'b0,5'd0, 1'b0,3'd0,3'd0,1'b0,2'd0,3'd0,1'b0,2'd1,1'b0,1'b0,3'd5,RB},  // R9 st3a
    '{1'b0,1'b1,1'b0,5'd0, 1'b0,3'd0,3'd0,1'b0,2'd0,3'd0,1'b0,2'd2,1'b0,1'b0,3'd5,FU},  // R9 res2
    '{1'b0,1'b1,1'b0,5'd0, 1'b0,3'd0,3'd0,1'b0,2'd0,3'd4,1'b0,2'd0,1'b0,1'b0,3'd4,AL},  // R5 left
    '{1'b1,1'b0,1'b0,5'd0, 1'b0,3'd0,3'd0,1'b0,2'd2,3'd0,1'b0,2'd0,1'b0,1'b0,3'd3,AL},  // R4 st3a cbus
    '{1'b0,1'b1,1'b0,5'd0, 1'b0,3'd0,3'd0,1'b0,2'd0,3'd0,1'b0,2'd1,1'b0,1'b0,3'd5,MI}   // R9 st3a from bus
  };

  logic clk = 1'b0, rst = 1'b1, ph_a = 1'b0, ph_b = 1'b0;
  logic [31:0] ram_a_rd = RA, ram_b_rd = RB, ifu_in = IFV, alu_res = AL, fu_res = FU, mem_in = MI;
  logic sel_const = 0, sel_field = 0, sel_st2b = 0, sel_res3 = 0, drv_res3 = 0, drv_mem = 0;
  logic [4:0] sel_right = 0;
  logic [2:0] sel_left = 0, sel_st2a = 0, sel_res2 = 0;
  logic [1:0] sel_st3a = 0, sel_mdrv = 0;
  logic [31:0] left_opnd, right_opnd, const_q, field_q, res2_q, mdrv_q, cbus;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opnd_route_dp u_opnd_route_dp (
    .clk(clk), .rst(rst), .ph_a(ph_a), .ph_b(ph_b),
    .ram_a_rd(ram_a_rd), .ram_b_rd(ram_b_rd), .ifu_in(ifu_in), .alu_res(alu_res),
    .fu_res(fu_res), .mem_in(mem_in), .sel_const(sel_const), .sel_right(sel_right),
    .sel_field(sel_field), .sel_left(sel_left), .sel_st2a(sel_st2a), .sel_st2b(sel_st2b),
    .sel_st3a(sel_st3a), .sel_res2(sel_res2), .sel_res3(sel_res3), .sel_mdrv(sel_mdrv),
    .drv_res3(drv_res3), .drv_mem(drv_mem), .left_opnd(left_opnd), .right_opnd(right_opnd),
    .const_q(const_q), .field_q(field_q), .res2_q(res2_q), .mdrv_q(mdrv_q), .cbus(cbus));

  function automatic logic [31:0] pick(input logic [2:0] o);
    case (o)
      3'd0: pick = left_opnd;
      3'd1: pick = right_opnd;
      3'd2: pick = const_q;
      3'd3: pick = field_q;
      3'd4: pick = res2_q;
      3'd5: pick = mdrv_q;
      default: pick = cbus;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    ph_a = v.pa; ph_b = v.pb; sel_const = v.sk; sel_right = v.sr; sel_field = v.sf;
    sel_left = v.sl; sel_st2a = v.s2a; sel_st2b = v.s2b; sel_st3a = v.s3a;
    sel_res2 = v.sr2; sel_res3 = v.sr3; sel_mdrv = v.sp; drv_res3 = v.d3; drv_mem = v.dm;
  endtask

  task automatic idle();
    apply('0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 left", left_opnd, 32'h0);
    check("R1 res2", res2_q, 32'h0);
    check("R1 cbus", cbus, 32'h0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      @(negedge clk);
      check($sformatf("R2-R9 row %0d", i), pick(VEC[i].obs), VEC[i].exp);
    end
    // R10 wrong phase: left select with only phase B
    idle(); ph_b = 1; sel_left = 3'b001;
    @(negedge clk);
    check("R10 wrong phase", left_opnd, AL);
    // R10 zero select on phase A
    idle(); ph_a = 1;
    @(negedge clk);
    check("R10 zero select right", right_opnd, MI);
    // R7 idle bus shows keeper
    idle();
    @(negedge clk);
    check("R7 keeper", cbus, MI);
    // R6 driver ignored outside phase B
    idle(); drv_res3 = 1;
    @(negedge clk);
    check("R6 no phase", cbus, MI);
    // R8 const ignores phase A
    idle(); ph_a = 1; sel_const = 1; ifu_in = 32'h1234_5678;
    @(negedge clk);
    check("R8 const phase", const_q, IFV);
    // R1 reset mid-run
    idle(); rst = 1;
    @(negedge clk);
    check("R1 reset field", field_q, 32'h0);
    check("R1 reset mdrv", mdrv_q, 32'h0);
    check("R1 reset cbus", cbus, 32'h0);
    rst = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule